// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL waveform timing for an I2C master. A functional clock is divided by a programmable prescaler into an internal tick. The bus clock then alternates between a low phase and a released (high) phase. Each phase length is counted in internal ticks and equals a programmed count plus a fixed hardware offset.

Each timing input packs two counts: the fast-mode count in its lower byte and the high-speed count in its upper byte. In standard and fast operation only the lower bytes are used. In high-speed operation the block starts on the lower bytes, which cover the slow arbitration and addressing phase. After a phase-switch strobe it moves to the upper bytes at the next phase boundary.

The block applies whatever counts it is given and never corrects the duty cycle. Software may program a near-even split, rounding the low count up so the low time is a little longer than the high time. It may also program a strongly skewed waveform.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `en` is high, `tick` pulses for one cycle every `psc`+1 functional clock cycles. The first pulse falls in the (`psc`+1)-th cycle after `en` rises.
- R2: A low phase (`scl_drive_low` = 1) lasts (low count + 7) ticks, that is (low count + 7)·(`psc`+1) clock cycles.
- R3: A released phase lasts (high count + 5) ticks, that is (high count + 5)·(`psc`+1) clock cycles.
- R4: In `scl_lo_cfg` and `scl_hi_cfg`, bits [7:0] hold the fast-mode count and bits [15:8] hold the high-speed count.
- R5: With `hs_mode` = 0, only bits [7:0] are used. The upper bytes and `hs_switch` have no effect on the waveform.
- R6: With `hs_mode` = 1, phases use the fast-mode counts until the first phase boundary after a `hs_switch` pulse. Every later phase uses the high-speed counts.
- R7: During reset and while `en` is low, `scl_drive_low` and `tick` are 0. The first low phase begins one tick after `en` rises, so SCL stays released for exactly `psc`+1 cycles.
- R8: A change of the timing inputs during a phase does not alter that phase. The new counts apply from the next phase boundary.
- R9: When `en` falls, `scl_drive_low` is 0 in the same cycle and all counters return to their reset state. A later enable restarts with the R7 timing.
- R10: No duty-cycle limit is enforced. A low count of 0 with a high count of 40 yields a 7-tick low and a 45-tick high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low releases SCL and clears all counters |
| hs_mode | input | 1 | 1 selects dual-phase high-speed operation |
| hs_switch | input | 1 | One-cycle strobe requesting the move to the high-speed counts |
| psc | input | 8 | Prescaler; tick period is psc+1 cycles |
| scl_lo_cfg | input | 16 | Low counts: [7:0] fast mode, [15:8] high speed |
| scl_hi_cfg | input | 16 | High counts: [7:0] fast mode, [15:8] high speed |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| tick | output | 1 | Internal tick strobe |

## Verification
The hardest case to reach from the ports is the high-speed switch. A strobe arriving in the middle of a released phase must leave the rest of that phase on the fast-mode count, and only the following low phase may use the upper byte. The stimulus watches `scl_drive_low` fall, pulses `hs_switch` a few cycles into that released phase, and predicts one fast-mode high phase followed by high-speed lows and highs. A second hard case is a timing change in the middle of a phase. The stimulus rewrites the low count once a low phase is seen to have started, and expects the old length once before the new one.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int unsigned LOW_OFFSET  = 7;
  localparam int unsigned HIGH_OFFSET = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_q, div_d;

  always_comb begin
    tick  = en && (div_q == psc);
    div_d = div_q;
    if (!en)       div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R1: after a tick, the next cycle cannot tick unless the divisor is one
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc != '0) |=> (!tick || psc == '0));
endmodule

// File: rtl/scl_len_sel.sv
module scl_len_sel #(
  parameter int FW = 8,
  parameter int LW = FW + 1
) (
  input  logic [2*FW-1:0] lo_cfg,
  input  logic [2*FW-1:0] hi_cfg,
  input  logic            use_hs,
  output logic [LW-1:0]   lo_len,
  output logic [LW-1:0]   hi_len
);
  import i2c_scl_pkg::*;

  logic [FW-1:0] lo_field [2];
  logic [FW-1:0] hi_field [2];

  for (genvar g = 0; g < 2; g++) begin : g_field
    assign lo_field[g] = lo_cfg[g*FW +: FW];
    assign hi_field[g] = hi_cfg[g*FW +: FW];
  end

  always_comb begin
    lo_len = {1'b0, lo_field[use_hs]} + LW'(LOW_OFFSET);
    hi_len = {1'b0, hi_field[use_hs]} + LW'(HIGH_OFFSET);
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          hs_mode,
  input  logic          hs_switch,
  input  logic [LW-1:0] lo_len,
  input  logic [LW-1:0] hi_len,
  output logic          use_hs,
  output logic          low_phase
);
  import i2c_scl_pkg::*;

  scl_phase_e    state_q, state_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_q, len_d;
  logic          hs_q, hs_d;
  logic          pend_q, pend_d;
  logic          start_ev, end_ev, swap;

  always_comb begin
    start_ev = tick && (state_q == PH_IDLE);
    end_ev   = tick && (state_q != PH_IDLE) && (cnt_q == len_q - 1'b1);
    swap     = start_ev || end_ev;
    use_hs   = hs_mode && (hs_q || pend_q || hs_switch);

    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    hs_d    = hs_q;
    pend_d  = pend_q;

    if (!en) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
      len_d   = '0;
      hs_d    = 1'b0;
      pend_d  = 1'b0;
    end else begin
      if (swap) begin
        cnt_d  = '0;
        hs_d   = use_hs;
        pend_d = 1'b0;
        if (state_q == PH_LOW) begin
          state_d = PH_HIGH;
          len_d   = hi_len;
        end else begin
          state_d = PH_LOW;
          len_d   = lo_len;
        end
      end else begin
        if (tick) cnt_d = cnt_q + 1'b1;
        if (hs_switch && hs_mode) pend_d = 1'b1;
      end
      if (!hs_mode) begin
        hs_d   = 1'b0;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      hs_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      hs_q    <= hs_d;
      pend_q  <= pend_d;
    end
  end

  assign low_phase = (state_q == PH_LOW);

  // R2 and R3: the phase counter never reaches the latched length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |-> (cnt_q < len_q));
  // R3: a finished low phase is always followed by a released phase
  p_low_to_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && end_ev && state_q == PH_LOW) |=> (state_q == PH_HIGH));
  // R8: the latched length holds for the whole phase
  p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q != PH_IDLE && !swap) |=> $stable(len_q));
  // R6: once on the high-speed counts, the selection stays there
  p_hs_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_q && en && hs_mode) |=> hs_q);
  // R9: disabling returns all state to reset
  p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == PH_IDLE && cnt_q == '0 && !hs_q && !pend_q));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int PSC_W = 8,
  parameter int FW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            hs_mode,
  input  logic            hs_switch,
  input  logic [PSC_W-1:0] psc,
  input  logic [2*FW-1:0] scl_lo_cfg,
  input  logic [2*FW-1:0] scl_hi_cfg,
  output logic            scl_drive_low,
  output logic            tick
);
  localparam int LW = FW + 1;

  logic          use_hs;
  logic          low_phase;
  logic [LW-1:0] lo_len, hi_len;

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .psc  (psc),
    .tick (tick)
  );

  scl_len_sel #(.FW(FW), .LW(LW)) u_sel (
    .lo_cfg(scl_lo_cfg),
    .hi_cfg(scl_hi_cfg),
    .use_hs(use_hs),
    .lo_len(lo_len),
    .hi_len(hi_len)
  );

  scl_phase_fsm #(.LW(LW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick     (tick),
    .hs_mode  (hs_mode),
    .hs_switch(hs_switch),
    .lo_len   (lo_len),
    .hi_len   (hi_len),
    .use_hs   (use_hs),
    .low_phase(low_phase)
  );

  assign scl_drive_low = en && low_phase;

  // R7: no tick and no low drive while disabled
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tick && !scl_drive_low));
endmodule

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        hs_mode = 1'b0;
  logic        hs_switch = 1'b0;
  logic [7:0]  psc = 8'd0;
  logic [15:0] scl_lo_cfg = 16'd0;
  logic [15:0] scl_hi_cfg = 16'd0;
  logic        scl_drive_low;
  logic        tick;

  always #5 clk = ~clk;

  i2c_scl_timer u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .hs_mode(hs_mode), .hs_switch(hs_switch),
    .psc(psc), .scl_lo_cfg(scl_lo_cfg), .scl_hi_cfg(scl_hi_cfg),
    .scl_drive_low(scl_drive_low), .tick(tick)
  );

  typedef struct {
    logic  lvl;
    int    len;
    string tag;
  } seg_t;

  seg_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   armed = 0;
  logic last_lvl = 1'b0;
  int   run = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic lvl, input int len, input string tag);
    seg_t s;
    s.lvl = lvl; s.len = len; s.tag = tag;
    q.push_back(s);
  endtask

  // monitor: measures run lengths of scl_drive_low and compares them
  always @(negedge clk) begin
    if (armed) begin
      if (scl_drive_low !== last_lvl) begin
        if (q.size() > 0) begin
          seg_t e;
          e = q.pop_front();
          check(last_lvl === e.lvl && run == e.len, e.tag, run, e.len);
        end
        last_lvl = scl_drive_low;
        run = 1;
      end else begin
        run++;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic start();
    step();
    last_lvl = 1'b0; run = 0; armed = 1;
    en = 1'b1;
  endtask

  task automatic drain_and_stop();
    while (q.size() != 0) @(negedge clk);
    step();
    armed = 0;
    en = 1'b0;
    step(); step();
  endtask

  task automatic wait_lvl(input logic v);
    @(negedge clk);
    while (scl_drive_low !== v) @(negedge clk);
  endtask

  initial begin
    #1500000;
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R7: reset state
    step(); step();
    check(scl_drive_low === 1'b0, "R7 reset drive", int'(scl_drive_low), 0);
    check(tick === 1'b0, "R7 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    step(); step();
    check(scl_drive_low === 1'b0, "R7 idle drive", int'(scl_drive_low), 0);

    // R1: tick spacing with psc=3
    psc = 8'd3;
    step();
    en = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
    check(n == 10, "R1 tick count", n, 10);
    step(); en = 1'b0; step(); step();

    // R2, R3, R7: basic fast-mode waveform, psc=0
    psc = 8'd0; scl_lo_cfg = 16'h0005; scl_hi_cfg = 16'h0009;
    push(0, 1, "R7 first release");
    push(1, 12, "R2 low psc0");
    push(0, 14, "R3 high psc0");
    push(1, 12, "R2 low psc0 again");
    start();
    drain_and_stop();

    // R2, R3 with psc=2
    psc = 8'd2; scl_lo_cfg = 16'h0003; scl_hi_cfg = 16'h0001;
    push(0, 3, "R7 first release psc2");
    push(1, 30, "R2 low psc2");
    push(0, 18, "R3 high psc2");
    push(1, 30, "R2 low psc2 again");
    start();
    drain_and_stop();

    // R10: skewed counts are honoured
    psc = 8'd0; scl_lo_cfg = 16'h0000; scl_hi_cfg = 16'h0028;
    push(0, 1, "R10 release");
    push(1, 7, "R10 minimum low");
    push(0, 45, "R10 long high");
    start();
    drain_and_stop();

    // R5: upper bytes and strobe ignored outside high-speed mode
    psc = 8'd1; hs_mode = 1'b0; scl_lo_cfg = 16'h1403; scl_hi_cfg = 16'h0002;
    push(0, 2, "R5 release");
    push(1, 20, "R5 low fast");
    push(0, 14, "R5 high fast");
    push(1, 20, "R5 low after strobe");
    push(0, 14, "R5 high after strobe");
    start();
    wait_lvl(1'b1); wait_lvl(1'b0);
    step(); hs_switch = 1'b1; step(); hs_switch = 1'b0;
    drain_and_stop();

    // R4, R6: high-speed dual phase
    hs_mode = 1'b1; scl_lo_cfg = 16'h0103; scl_hi_cfg = 16'h0002;
    push(0, 2, "R6 release");
    push(1, 20, "R6 first low fast byte");
    push(0, 14, "R6 high keeps fast byte");
    push(1, 16, "R4 low upper byte");
    push(0, 10, "R4 high upper byte");
    push(1, 16, "R6 stays high speed");
    start();
    wait_lvl(1'b1); wait_lvl(1'b0);
    step(); hs_switch = 1'b1; step(); hs_switch = 1'b0;
    drain_and_stop();
    hs_mode = 1'b0;

    // R8: change during a low phase applies from the next low
    psc = 8'd0; scl_lo_cfg = 16'h0004; scl_hi_cfg = 16'h0003;
    push(0, 1, "R8 release");
    push(1, 11, "R8 current low unchanged");
    push(0, 8, "R8 high");
    push(1, 17, "R8 next low new count");
    start();
    wait_lvl(1'b1);
    step(); scl_lo_cfg = 16'h000A;
    drain_and_stop();

    // R9: disable mid low releases at once, then restart
    psc = 8'd1; scl_lo_cfg = 16'h0005; scl_hi_cfg = 16'h0002;
    step(); en = 1'b1;
    wait_lvl(1'b1);
    step(); step();
    en = 1'b0;
    #2;
    check(scl_drive_low === 1'b0, "R9 immediate release", int'(scl_drive_low), 0);
    step(); step();
    @(negedge clk);
    check(tick === 1'b0 && scl_drive_low === 1'b0, "R9 stays idle", int'(tick), 0);
    push(0, 2, "R9 restart release");
    push(1, 24, "R9 restart low");
    start();
    drain_and_stop();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule